// File: doc/BRIEF.md
# Memory Semaphore Command Engine

This block carries out one synchronisation command at a time against a 32-bit word held in memory. A command names a byte address, a 32-bit payload, an operation, a reduction kind, a signed/unsigned flag and a flag that asks for a timestamp. Release stores the payload. The two acquire forms keep reading the word until it matches the payload, either exactly or by being at least as large. A reduction reads the word, combines it with the payload and stores the result back to the same address. Only one access is in flight at any time, so the sequence of accesses is the whole effect.

Commands arrive over a valid/ready handshake. Memory is reached through a request/grant port with a separate read-response strobe. A free-running 64-bit time counter is sampled when a command is accepted. When the stamp flag is set, that sample goes to memory before the operation starts. A one-cycle completion pulse marks the end of each command. A command with an operation code the block does not know is taken and dropped, and a one-cycle warning pulse is raised.

Top module: `sem_exec`

## Requirements
- R1: Operation code 1 (release) makes exactly one write of the payload to the command address and no read.
- R2: With the stamp flag set, the time sampled in the accept cycle is written before any other access of that command: the low 32 bits at address+8, then the high 32 bits at address+12.
- R3: Operation code 0 (acquire-equal) reads the address again and again until a read returns a value equal to the payload. A larger value does not end the wait. It never writes the word.
- R4: Operation code 2 (acquire-at-least) reads again and again until a read returns a value that is not less than the payload under an unsigned compare.
- R5: Operation code 3 (reduction) makes one read of the address and then one write of the computed value to the same address.
- R6: Reduction kinds 0 (minimum), 1 (maximum) and 5 (add) compare or add as signed 32-bit numbers when the signed flag is 1 and as unsigned numbers when it is 0. Add wraps modulo 2^32.
- R7: Reduction kinds 2 (xor), 3 (and) and 4 (or) combine the old word and the payload bit by bit, and the signed flag has no effect on the result.
- R8: Reduction kind 6 (increment) stores 0 when the old word is not below the payload (unsigned). Otherwise it stores the old word plus 1.
- R9: Reduction kind 7 (decrement) stores the payload when the old word is 0 or is above the payload (unsigned). Otherwise it stores the old word minus 1.
- R10: Operation codes 4 to 7 are accepted, make no memory access and no completion pulse, and raise the warning output for exactly the one cycle after acceptance.
- R11: cmd_ready is high only while no command is in progress, including out of reset. A request is held with the same address and direction until granted. Only one read is outstanding. After a failed poll response the next poll request appears exactly POLL_GAP+1 cycles later.
- R12: done is high for exactly one cycle: the cycle after the grant of a command's last write, or the cycle after the read response that satisfies an acquire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_addr | input | ADDR_W | Byte address of the semaphore word |
| cmd_payload | input | 32 | Payload operand |
| cmd_op | input | 3 | Operation code |
| cmd_kind | input | 3 | Reduction kind |
| cmd_signed | input | 1 | Signed arithmetic for min, max and add |
| cmd_stamp | input | 1 | Write the timestamp first |
| timestamp | input | 64 | Free-running time counter |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | Command completed pulse |
| warn | output | 1 | Unknown operation pulse |

## Verification
A wrong phase register shows up at once on the memory port. The grant after it carries an unexpected address, direction or data, or a request appears while no command is running. The reference flags it in that same cycle. A wrong operand or reduction result reaches the port as write data in the cycle the final write is granted. A wrong poll comparison shows up one cycle after the deciding response, as a missing or early done pulse or a poll request in the wrong cycle. A stuck busy state is caught on the next clock because cmd_ready no longer matches the idle prediction.

// File: rtl/sem_pkg.sv
package sem_pkg;
    localparam int WORD_W      = 32;
    localparam int STAMP_W     = 64;
    localparam int STAMP_WORDS = STAMP_W / WORD_W;
    localparam int WORD_SHIFT  = $clog2(WORD_W / 8);
    localparam int STAMP_OFS   = 8;

    localparam logic [2:0] OP_ACQ_EQ  = 3'd0;
    localparam logic [2:0] OP_RELEASE = 3'd1;
    localparam logic [2:0] OP_ACQ_GEQ = 3'd2;
    localparam logic [2:0] OP_REDUCE  = 3'd3;

    typedef enum logic [2:0] {
        RK_MIN = 3'd0,
        RK_MAX = 3'd1,
        RK_XOR = 3'd2,
        RK_AND = 3'd3,
        RK_OR  = 3'd4,
        RK_ADD = 3'd5,
        RK_INC = 3'd6,
        RK_DEC = 3'd7
    } red_kind_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_STAMP   = 3'd1,
        S_RD      = 3'd2,
        S_RD_WAIT = 3'd3,
        S_GAP     = 3'd4,
        S_WR      = 3'd5
    } sem_state_e;
endpackage

// File: rtl/sem_reduce.sv
module sem_reduce
    import sem_pkg::*;
(
    input  logic [WORD_W-1:0] orig,
    input  logic [WORD_W-1:0] operand,
    input  red_kind_e         kind,
    input  logic              is_signed,
    output logic [WORD_W-1:0] result
);
    logic below;

    // ordering used by min and max; signedness only matters here
    always_comb begin
        if (is_signed) below = $signed(orig) < $signed(operand);
        else           below = orig < operand;
    end

    always_comb begin
        unique case (kind)
            RK_MIN:  result = below ? orig : operand;
            RK_MAX:  result = below ? operand : orig;
            RK_XOR:  result = orig ^ operand;
            RK_AND:  result = orig & operand;
            RK_OR:   result = orig | operand;
            RK_ADD:  result = orig + operand;
            RK_INC:  result = (orig >= operand) ? '0 : orig + 1'b1;
            RK_DEC:  result = (orig == '0 || orig > operand) ? operand : orig - 1'b1;
            default: result = orig;
        endcase
    end
endmodule

// File: rtl/sem_poll_cmp.sv
module sem_poll_cmp
    import sem_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] target,
    input  logic              at_least,
    output logic              hit
);
    always_comb begin
        if (at_least) hit = (word >= target);
        else          hit = (word == target);
    end
endmodule

// File: rtl/sem_exec.sv
module sem_exec
    import sem_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int POLL_GAP = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [WORD_W-1:0]     cmd_payload,
    input  logic [2:0]            cmd_op,
    input  logic [2:0]            cmd_kind,
    input  logic                  cmd_signed,
    input  logic                  cmd_stamp,
    input  logic [STAMP_W-1:0]    timestamp,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]     mem_wdata,
    input  logic                  mem_gnt,
    input  logic                  mem_rsp_valid,
    input  logic [WORD_W-1:0]     mem_rsp_data,
    output logic                  done,
    output logic                  warn
);
    localparam int GAP_W = (POLL_GAP > 0) ? $clog2(POLL_GAP + 1) : 1;
    localparam int IDX_W = (STAMP_WORDS > 1) ? $clog2(STAMP_WORDS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(STAMP_WORDS - 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'((POLL_GAP > 0) ? POLL_GAP - 1 : 0);

    typedef struct packed {
        sem_state_e         st;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  pay;
        logic [2:0]         op;
        red_kind_e          kind;
        logic               sgn;
        logic [STAMP_W-1:0] ts;
        logic [WORD_W-1:0]  wdata;
        logic [IDX_W-1:0]   idx;
        logic [GAP_W-1:0]   gap;
        logic               done;
        logic               warn;
    } regs_t;

    regs_t r_d, r_q;

    logic [WORD_W-1:0] red_res;
    logic              poll_hit;

    sem_reduce u_reduce (
        .orig      (mem_rsp_data),
        .operand   (r_q.pay),
        .kind      (r_q.kind),
        .is_signed (r_q.sgn),
        .result    (red_res)
    );

    sem_poll_cmp u_poll (
        .word     (mem_rsp_data),
        .target   (r_q.pay),
        .at_least (r_q.op == OP_ACQ_GEQ),
        .hit      (poll_hit)
    );

    function automatic sem_state_e entry_state(input logic [2:0] op);
        return (op == OP_RELEASE) ? S_WR : S_RD;
    endfunction

    function automatic logic op_known(input logic [2:0] op);
        return (op == OP_ACQ_EQ) || (op == OP_RELEASE) ||
               (op == OP_ACQ_GEQ) || (op == OP_REDUCE);
    endfunction

    // next-state computation
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.warn = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (op_known(cmd_op)) begin
                        r_d.addr  = cmd_addr;
                        r_d.pay   = cmd_payload;
                        r_d.op    = cmd_op;
                        r_d.kind  = red_kind_e'(cmd_kind);
                        r_d.sgn   = cmd_signed;
                        r_d.ts    = timestamp;
                        r_d.wdata = cmd_payload;
                        r_d.idx   = '0;
                        r_d.st    = cmd_stamp ? S_STAMP : entry_state(cmd_op);
                    end else begin
                        r_d.warn = 1'b1;
                    end
                end
            end
            S_STAMP: begin
                if (mem_gnt) begin
                    if (r_q.idx == IDX_LAST) r_d.st  = entry_state(r_q.op);
                    else                     r_d.idx = r_q.idx + 1'b1;
                end
            end
            S_RD: begin
                if (mem_gnt) r_d.st = S_RD_WAIT;
            end
            S_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    if (r_q.op == OP_REDUCE) begin
                        r_d.wdata = red_res;
                        r_d.st    = S_WR;
                    end else if (poll_hit) begin
                        r_d.st   = S_IDLE;
                        r_d.done = 1'b1;
                    end else if (POLL_GAP == 0) begin
                        r_d.st = S_RD;
                    end else begin
                        r_d.st  = S_GAP;
                        r_d.gap = GAP_LOAD;
                    end
                end
            end
            S_GAP: begin
                if (r_q.gap == '0) r_d.st  = S_RD;
                else               r_d.gap = r_q.gap - 1'b1;
            end
            S_WR: begin
                if (mem_gnt) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // port drive
    always_comb begin
        cmd_ready = (r_q.st == S_IDLE);
        mem_req   = (r_q.st == S_STAMP) || (r_q.st == S_RD) || (r_q.st == S_WR);
        mem_we    = (r_q.st != S_RD);
        if (r_q.st == S_STAMP) begin
            mem_addr  = r_q.addr + ADDR_W'(STAMP_OFS) + (ADDR_W'(r_q.idx) << WORD_SHIFT);
            mem_wdata = r_q.ts[r_q.idx*WORD_W +: WORD_W];
        end else begin
            mem_addr  = r_q.addr;
            mem_wdata = r_q.wdata;
        end
        done = r_q.done;
        warn = r_q.warn;
    end

    // checks
    p_busy_noready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cmd_ready);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_req && mem_gnt && mem_we) || $past(mem_rsp_valid)));

    p_warn_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        warn |-> (!done && !mem_req && cmd_ready));

    p_inc_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RD_WAIT && mem_rsp_valid && r_q.op == OP_REDUCE && r_q.kind == RK_INC)
        |=> (mem_we && (mem_wdata == '0 || mem_wdata <= r_q.pay)));
endmodule

// File: tb/sem_exec_test.sv
`timescale 1ns/1ps
module sem_exec_test;
    localparam int POLL_GAP = 2;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_payload = '0;
    logic [2:0]  cmd_op = '0;
    logic [2:0]  cmd_kind = '0;
    logic        cmd_signed = 1'b0;
    logic        cmd_stamp = 1'b0;
    logic [63:0] timestamp = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, warn;

    always #4 clk = ~clk;

    sem_exec #(.ADDR_W(32), .POLL_GAP(POLL_GAP)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_payload(cmd_payload), .cmd_op(cmd_op),
        .cmd_kind(cmd_kind), .cmd_signed(cmd_signed), .cmd_stamp(cmd_stamp),
        .timestamp(timestamp), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .warn(warn)
    );

    bit [31:0] mem [bit [31:0]];
    int total = 0, bad = 0, cyc = 0;

    // reference state
    bit        have_cmd = 0, m_busy = 0;
    int        m_phase = 0;          // 0 none, 1 stamp, 2 read, 3 write
    int        m_stamp_left = 0, m_reads = 0;
    bit [2:0]  m_op, m_kind;
    bit        m_sgn;
    bit [31:0] m_addr, m_pay, m_wexp;
    bit [63:0] m_ts;
    bit        exp_ready = 1, exp_done = 0, exp_warn = 0;
    bit        rd_pend = 0;
    int        rd_cyc = 0;
    bit        gap_wait = 0;
    int        fail_cyc = 0;
    int        flip_cnt = 0;
    bit [31:0] flip_val = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic bit [31:0] ref_red(input bit [2:0] k, input bit s, input bit [31:0] o, input bit [31:0] p);
        int so, sp;
        so = o; sp = p;
        case (k)
            3'd0: ref_red = s ? ((so < sp) ? o : p) : ((o < p) ? o : p);
            3'd1: ref_red = s ? ((so > sp) ? o : p) : ((o > p) ? o : p);
            3'd2: ref_red = o ^ p;
            3'd3: ref_red = o & p;
            3'd4: ref_red = o | p;
            3'd5: ref_red = o + p;
            3'd6: ref_red = (o >= p) ? 32'd0 : o + 32'd1;
            default: ref_red = (o == 0 || o > p) ? p : o - 32'd1;
        endcase
    endfunction

    function automatic string kind_tag(input bit [2:0] k);
        case (k)
            3'd0, 3'd1, 3'd5: kind_tag = "R6";
            3'd2, 3'd3, 3'd4: kind_tag = "R7";
            3'd6:             kind_tag = "R8";
            default:          kind_tag = "R9";
        endcase
    endfunction

    task automatic step();
        bit exp_done_n, exp_warn_n, exp_ready_n, hit;
        bit [31:0] rdat;
        int idx;
        @(negedge clk);
        cyc++;
        if (cyc > WD_LIMIT) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        check(cmd_ready == exp_ready, "R11 cmd_ready", cmd_ready, exp_ready);
        check(done == exp_done, "R12 done pulse", done, exp_done);
        check(warn == exp_warn, "R10 warn pulse", warn, exp_warn);
        check(!(mem_req && !m_busy), "R10 access while idle", mem_req, 0);
        exp_done_n = 0; exp_warn_n = 0; exp_ready_n = exp_ready;

        timestamp  = 64'hC0DE_0000_0000_0000 + 64'(cyc) * 64'd13 + (64'(cyc) << 36);
        cmd_valid  = have_cmd;
        mem_gnt    = (cyc % 3) != 0;
        mem_rsp_valid = 0;
        mem_rsp_data  = '0;
        if (rd_pend && cyc == rd_cyc) begin
            mem_rsp_valid = 1;
            mem_rsp_data  = mem[m_addr];
            rd_pend = 0;
        end

        if (gap_wait && mem_req) begin
            check(cyc - fail_cyc == POLL_GAP + 1, "R11 poll spacing", cyc - fail_cyc, POLL_GAP + 1);
            gap_wait = 0;
        end

        if (cmd_valid && cmd_ready) begin
            have_cmd = 0;
            if (cmd_op > 3'd3) begin
                exp_warn_n = 1;
            end else begin
                m_busy = 1; exp_ready_n = 0;
                m_op = cmd_op; m_kind = cmd_kind; m_sgn = cmd_signed;
                m_addr = cmd_addr; m_pay = cmd_payload; m_ts = timestamp;
                m_reads = 0; m_wexp = cmd_payload;
                if (cmd_stamp) begin m_phase = 1; m_stamp_left = 2; end
                else m_phase = (cmd_op == 3'd1) ? 3 : 2;
            end
        end

        if (mem_req && mem_gnt) begin
            if (m_phase == 1) begin
                idx = 2 - m_stamp_left;
                check(mem_we && mem_addr == m_addr + 32'd8 + 32'(idx * 4), "R2 stamp address", {mem_we, mem_addr}, {1'b1, m_addr + 32'd8 + 32'(idx * 4)});
                check(mem_wdata == m_ts[idx*32 +: 32], "R2 stamp data", mem_wdata, m_ts[idx*32 +: 32]);
                m_stamp_left--;
                if (m_stamp_left == 0) m_phase = (m_op == 3'd1) ? 3 : 2;
            end else if (m_phase == 2) begin
                check(!mem_we && mem_addr == m_addr, (m_op == 3'd3) ? "R5 read" : "R3 poll read", {mem_we, mem_addr}, {1'b0, m_addr});
                m_reads++;
                rd_pend = 1;
                rd_cyc = cyc + 1 + (cyc % 2);
                m_phase = 4;
            end else if (m_phase == 3) begin
                check(mem_we && mem_addr == m_addr, (m_op == 3'd1) ? "R1 write address" : "R5 write address", {mem_we, mem_addr}, {1'b1, m_addr});
                check(mem_wdata == m_wexp, (m_op == 3'd1) ? "R1 write data" : kind_tag(m_kind), mem_wdata, m_wexp);
                m_phase = 0; m_busy = 0; exp_done_n = 1; exp_ready_n = 1;
            end else begin
                check(0, "R11 unexpected access", {mem_we, mem_addr}, 0);
            end
            if (mem_we) mem[mem_addr] = mem_wdata;
        end

        if (mem_rsp_valid) begin
            rdat = mem_rsp_data;
            if (m_op == 3'd3) begin
                m_wexp = ref_red(m_kind, m_sgn, rdat, m_pay);
                m_phase = 3;
            end else begin
                hit = (m_op == 3'd0) ? (rdat == m_pay) : (rdat >= m_pay);
                if (hit) begin
                    m_phase = 0; m_busy = 0; exp_done_n = 1; exp_ready_n = 1;
                end else begin
                    m_phase = 2; gap_wait = 1; fail_cyc = cyc;
                end
                if (flip_cnt > 0) begin
                    flip_cnt--;
                    if (flip_cnt == 0) mem[m_addr] = flip_val;
                end
            end
        end

        exp_done = exp_done_n; exp_warn = exp_warn_n; exp_ready = exp_ready_n;
    endtask

    task automatic run_cmd(input bit [2:0] op, input bit [2:0] kind, input bit sgn,
                           input bit stamp, input bit [31:0] addr, input bit [31:0] pay);
        cmd_op = op; cmd_kind = kind; cmd_signed = sgn; cmd_stamp = stamp;
        cmd_addr = addr; cmd_payload = pay; have_cmd = 1;
        while (have_cmd || m_busy) step();
        step();
        step();
    endtask

    bit [31:0] origs [5] = '{32'hFFFF_FFFE, 32'd5, 32'd0, 32'd9, 32'h7FFF_FFFF};
    bit [31:0] pays  [5] = '{32'd3, 32'd5, 32'd7, 32'd4, 32'd1};

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_ready === 1'b1, "R11 reset ready", cmd_ready, 1);
        check(mem_req === 1'b0, "R11 reset no request", mem_req, 0);
        check(done === 1'b0, "R12 reset done", done, 0);
        check(warn === 1'b0, "R10 reset warn", warn, 0);
        rst_n = 1'b1;
        step();

        // R1 plain release
        run_cmd(3'd1, 3'd0, 0, 0, 32'h100, 32'h1234_5678);
        check(mem[32'h100] == 32'h1234_5678, "R1 stored word", mem[32'h100], 32'h1234_5678);

        // R2 release with stamp
        run_cmd(3'd1, 3'd0, 0, 1, 32'h200, 32'hDEAD_BEEF);
        check(mem[32'h200] == 32'hDEAD_BEEF, "R2 release after stamp", mem[32'h200], 32'hDEAD_BEEF);
        check(mem[32'h208] == m_ts[31:0] && mem[32'h20C] == m_ts[63:32], "R2 stamp stored",
              {mem[32'h20C], mem[32'h208]}, m_ts);

        // R3 acquire-equal: larger value does not satisfy
        mem[32'h300] = 32'd10; flip_cnt = 3; flip_val = 32'd9;
        run_cmd(3'd0, 3'd0, 0, 0, 32'h300, 32'd9);
        check(m_reads == 4, "R3 poll count", m_reads, 4);
        check(mem[32'h300] == 32'd9, "R3 word untouched", mem[32'h300], 9);

        // R4 acquire-at-least, unsigned compare, with stamp
        mem[32'h400] = 32'h7FFF_FFFF; flip_cnt = 2; flip_val = 32'h8000_0001;
        run_cmd(3'd2, 3'd0, 1, 1, 32'h400, 32'h8000_0000);
        check(m_reads == 3, "R4 poll count", m_reads, 3);
        check(mem[32'h408] == m_ts[31:0], "R2 stamp before acquire", mem[32'h408], m_ts[31:0]);

        // R4 satisfied on first read
        mem[32'h480] = 32'hFFFF_FFFF; flip_cnt = 0;
        run_cmd(3'd2, 3'd0, 0, 0, 32'h480, 32'h10);
        check(m_reads == 1, "R4 immediate", m_reads, 1);

        // R5..R9 reductions
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < 2; s++) begin
                for (int v = 0; v < 5; v++) begin
                    bit [31:0] a, e;
                    a = 32'h1000 + 32'(k * 64 + s * 32 + v * 4);
                    mem[a] = origs[v];
                    e = ref_red(3'(k), s[0], origs[v], pays[v]);
                    run_cmd(3'd3, 3'(k), s[0], 0, a, pays[v]);
                    check(mem[a] == e, kind_tag(3'(k)), mem[a], e);
                    check(m_reads == 1, "R5 single read", m_reads, 1);
                end
            end
        end

        // R6 spot values computed by hand
        mem[32'h2000] = 32'hFFFF_FFFE;
        run_cmd(3'd3, 3'd0, 1, 0, 32'h2000, 32'd3);
        check(mem[32'h2000] == 32'hFFFF_FFFE, "R6 signed min", mem[32'h2000], 32'hFFFF_FFFE);
        mem[32'h2004] = 32'hFFFF_FFFF;
        run_cmd(3'd3, 3'd5, 0, 0, 32'h2004, 32'd2);
        check(mem[32'h2004] == 32'd1, "R6 add wraps", mem[32'h2004], 1);
        // R8 / R9 bounds
        mem[32'h2008] = 32'd7;
        run_cmd(3'd3, 3'd6, 0, 0, 32'h2008, 32'd7);
        check(mem[32'h2008] == 32'd0, "R8 increment wraps", mem[32'h2008], 0);
        mem[32'h200C] = 32'd0;
        run_cmd(3'd3, 3'd7, 0, 0, 32'h200C, 32'd6);
        check(mem[32'h200C] == 32'd6, "R9 decrement from zero", mem[32'h200C], 6);

        // R10 unknown operation codes
        mem[32'h700] = 32'h55;
        for (int op = 4; op < 8; op++) begin
            run_cmd(3'(op), 3'd2, 0, 1, 32'h700, 32'hFF);
            check(mem[32'h700] == 32'h55 && mem[32'h708] == 0, "R10 no memory change", mem[32'h700], 32'h55);
        end

        // R1 again back-to-back after an unknown code
        run_cmd(3'd1, 3'd0, 0, 0, 32'h700, 32'h66);
        check(mem[32'h700] == 32'h66, "R1 after dropped command", mem[32'h700], 32'h66);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule